// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block collects interrupt requests from PCI agents and from two extra steerable inputs, and places each one on a legacy interrupt request line chosen by software. Each source has a routing entry that holds an enable bit and a 4-bit target line number. Every line then gets a per-line trigger setting. In level mode the line follows the combined request. In edge mode the line emits a one-cycle pulse when the combined request rises. The same block also latches a non-maskable interrupt from the system-error and ISA parity-error inputs.

The PCI requests arrive in one of two ways, chosen by a strap input. In direct mode, four active-low pins carry sources 0 to 3 and sources 4 to 7 stay inactive. In polled mode the first pin becomes a shared serial input, and the other three pins become a 3-bit select output that steps through all eight sources, one per clock. An external multiplexer places the addressed source on the shared input. The captured values are committed as a group once per scan. Priority resolution and the CPU acknowledge cycle belong to the downstream interrupt controller.

Top module: `irq_steer_router`

## Requirements
- R1: A source whose routing entry is enabled drives its target line in level mode. A routing entry is written at cfg_addr i (0 to 7 for PCI sources, 8 to 9 for the extra inputs), with cfg_wdata[4] as the enable and cfg_wdata[3:0] as the target line. PCI sources are asserted when low. Extra inputs are asserted when high.
- R2: A disabled entry drives nothing. Lines 0 and 2, which are cleared in the default AVAIL_MASK, are never asserted.
- R3: Sources that share a target line are ORed onto that line.
- R4: In direct mode (poll_mode low), inta_n carries source 0 and intbcd_in_n[2:0] carry sources 1 to 3. Sources 4 to 7 are inactive. A change on a pin appears on irq_out after the second rising clock edge.
- R5: While poll_mode is high, intbcd_oe is high and intbcd_out advances by one, modulo 8, on every clock. While poll_mode is low, intbcd_oe is low and intbcd_out is 0.
- R6: In polled mode, inta_n is captured for the source named by intbcd_out at each edge. All eight captured values take effect together at the edge where intbcd_out is 7, and they appear on irq_out one edge later.
- R7: The trigger register at cfg_addr 10 has one bit per line, where 1 selects edge mode. An edge-mode line pulses high for exactly one cycle when its combined request rises. It does not pulse again until every source sharing the line has gone inactive.
- R8: A low on serr_n or iochk_n at a clock edge sets nmi when NMI is unmasked. nmi then stays high after the error input returns high.
- R9: A write to cfg_addr 11 sets the NMI mask from cfg_wdata[0]. A write with cfg_wdata[0] or cfg_wdata[1] set clears nmi. While the mask is set, error inputs have no effect on nmi.
- R10: Reset leaves irq_out and nmi low, the select at 0, every routing entry disabled, every line in level mode and NMI unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| poll_mode | input | 1 | Strap: 1 selects polled collection of PCI requests |
| inta_n | input | 1 | Source 0 request in direct mode; shared polled input in polled mode |
| intbcd_in_n | input | 3 | Sources 1 to 3 requests in direct mode |
| intbcd_out | output | 3 | Polling select driven onto the shared pins |
| intbcd_oe | output | 1 | Output enable for intbcd_out |
| xirq | input | 2 | Extra steerable requests, active high (entries 8 and 9) |
| serr_n | input | 1 | System error, active low |
| iochk_n | input | 1 | ISA parity error, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| irq_out | output | 16 | Legacy interrupt request lines, active high |
| nmi | output | 1 | Latched non-maskable interrupt to the CPU |

## Verification
A vector table drives single direct pins, pairs of sources that share one line, a source steered to a reserved line, a disabled extra input and all sources at once. These vectors separate mapping errors from OR-merging errors and from errors in masking reserved lines. The edge-mode sequence overlaps two sharers and then releases them one at a time. This shows whether the converter acts on the merged request or on the individual sources. In polled mode the select sequence is checked, and a single source is changed right after select 0 is seen. This confirms that the output holds until the scan commits and changes exactly one cycle after that. The NMI sequence pulses each error input, then clears, masks and unmasks the latch, which tells sticky behaviour apart from level-following behaviour.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  // width of a target line number and the resulting line count
  localparam int unsigned LINE_W = 4;
  localparam int unsigned N_LINE = 1 << LINE_W;

  typedef struct packed {
    logic              en;
    logic [LINE_W-1:0] tgt;
  } route_ent_t;

  localparam int unsigned ENT_W = LINE_W + 1;
endpackage

// File: rtl/poll_capture.sv
module poll_capture #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_mode,
  input  logic             inta_n,
  input  logic [SEL_W-1:0] direct_bcd_n,
  output logic [SEL_W-1:0] sel_q,
  output logic [N_SRC-1:0] req_q
);
  localparam int unsigned N_DIR = SEL_W + 1;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_SRC - 1);

  logic [SEL_W-1:0] sel_d;
  logic [N_SRC-1:0] shadow_q, shadow_d, req_d;

  always_comb begin
    sel_d    = '0;
    shadow_d = shadow_q;
    req_d    = req_q;
    if (poll_mode) begin
      sel_d           = sel_q + 1'b1;
      shadow_d[sel_q] = ~inta_n;
      if (sel_q == LAST) req_d = shadow_d;
    end else begin
      req_d            = '0;
      req_d[N_DIR-1:0] = ~{direct_bcd_n, inta_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      shadow_q <= '0;
      req_q    <= '0;
    end else begin
      sel_q    <= sel_d;
      shadow_q <= shadow_d;
      req_q    <= req_d;
    end
  end
endmodule

// File: rtl/route_table.sv
module route_table
  import irq_steer_pkg::*;
#(
  parameter int unsigned N_ENT      = 10,
  parameter int unsigned AW         = 4,
  parameter logic [N_LINE-1:0] AVAIL_MASK = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [ENT_W-1:0]  cfg_wdata,
  input  logic [N_ENT-1:0]  req,
  output logic [N_LINE-1:0] line_hit
);
  route_ent_t ent_q [N_ENT];
  route_ent_t ent_d [N_ENT];
  logic [N_LINE-1:0] raw_hit;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      ent_d[i] = ent_q[i];
      if (cfg_we && cfg_addr == AW'(i)) ent_d[i] = route_ent_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= ent_d[i];
    end
  end

  // one OR tree per line over every entry that names it
  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    always_comb begin
      raw_hit[l] = 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
        if (ent_q[i].en && ent_q[i].tgt == LINE_W'(l) && req[i]) raw_hit[l] = 1'b1;
      end
    end
  end

  assign line_hit = raw_hit & AVAIL_MASK;
endmodule

// File: rtl/line_driver.sv
module line_driver
  import irq_steer_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter int unsigned TRIG_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [N_LINE-1:0] cfg_wdata,
  input  logic [N_LINE-1:0] line_hit,
  output logic [N_LINE-1:0] trig_q,
  output logic [N_LINE-1:0] irq_q
);
  logic [N_LINE-1:0] trig_d, prev_q, irq_d;
  logic              trig_wr;

  assign trig_wr = cfg_we && (cfg_addr == AW'(TRIG_ADDR));
  assign trig_d  = trig_wr ? cfg_wdata : trig_q;

  for (genvar l = 0; l < N_LINE; l++) begin : g_drv
    always_comb begin
      if (trig_q[l]) irq_d[l] = line_hit[l] & ~prev_q[l];
      else           irq_d[l] = line_hit[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      prev_q <= '0;
      irq_q  <= '0;
    end else begin
      trig_q <= trig_d;
      prev_q <= line_hit;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch #(
  parameter int unsigned AW       = 4,
  parameter int unsigned NMI_ADDR = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [1:0]    cfg_wdata,
  input  logic          serr_n,
  input  logic          iochk_n,
  output logic          mask_q,
  output logic          nmi_q
);
  logic wr, mask_d, nmi_d;

  assign wr = cfg_we && (cfg_addr == AW'(NMI_ADDR));

  always_comb begin
    mask_d = wr ? cfg_wdata[0] : mask_q;
    nmi_d  = nmi_q;
    if (wr && (cfg_wdata[0] || cfg_wdata[1])) nmi_d = 1'b0;
    else if ((!serr_n || !iochk_n) && !mask_q) nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      nmi_q  <= nmi_d;
    end
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned N_XTRA = 2,
  parameter int unsigned CFG_AW = 4,
  parameter int unsigned CFG_DW = 16,
  parameter logic [N_LINE-1:0] AVAIL_MASK = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_mode,
  input  logic              inta_n,
  input  logic [$clog2(N_SRC)-1:0] intbcd_in_n,
  output logic [$clog2(N_SRC)-1:0] intbcd_out,
  output logic              intbcd_oe,
  input  logic [N_XTRA-1:0] xirq,
  input  logic              serr_n,
  input  logic              iochk_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [N_LINE-1:0] irq_out,
  output logic              nmi
);
  localparam int unsigned SEL_W     = $clog2(N_SRC);
  localparam int unsigned N_ENT     = N_SRC + N_XTRA;
  localparam int unsigned ADDR_TRIG = N_ENT;
  localparam int unsigned ADDR_NMI  = N_ENT + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [N_SRC-1:0]  pci_req;
  logic [N_XTRA-1:0] xirq_q;
  logic [N_LINE-1:0] line_hit;
  logic [N_LINE-1:0] trig_mask;
  logic              nmi_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) xirq_q <= '0;
    else             xirq_q <= xirq;
  end

  assign intbcd_oe = poll_mode;

  poll_capture #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_poll (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .poll_mode    (poll_mode),
    .inta_n       (inta_n),
    .direct_bcd_n (intbcd_in_n),
    .sel_q        (intbcd_out),
    .req_q        (pci_req)
  );

  route_table #(.N_ENT(N_ENT), .AW(CFG_AW), .AVAIL_MASK(AVAIL_MASK)) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata[ENT_W-1:0]),
    .req       ({xirq_q, pci_req}),
    .line_hit  (line_hit)
  );

  line_driver #(.AW(CFG_AW), .TRIG_ADDR(ADDR_TRIG)) u_line (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata[N_LINE-1:0]),
    .line_hit  (line_hit),
    .trig_q    (trig_mask),
    .irq_q     (irq_out)
  );

  nmi_latch #(.AW(CFG_AW), .NMI_ADDR(ADDR_NMI)) u_nmi (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata[1:0]),
    .serr_n    (serr_n),
    .iochk_n   (iochk_n),
    .mask_q    (nmi_mask),
    .nmi_q     (nmi)
  );
endmodule

// File: rtl/irq_steer_router_chk.sv
module irq_steer_router_chk
  import irq_steer_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned CFG_AW   = 4,
  parameter int unsigned NMI_ADDR = 11,
  parameter logic [N_LINE-1:0] AVAIL_MASK = 16'hFFFA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_mode,
  input logic [SEL_W-1:0]  intbcd_out,
  input logic [N_LINE-1:0] irq_out,
  input logic [N_LINE-1:0] trig_mask,
  input logic              nmi,
  input logic              nmi_mask,
  input logic              serr_n,
  input logic              iochk_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr
);
  logic nmi_wr;
  assign nmi_wr = cfg_we && (cfg_addr == CFG_AW'(NMI_ADDR));

  // R5
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_mode && $past(poll_mode)) |-> intbcd_out == SEL_W'($past(intbcd_out) + 1'b1));

  // R5
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!poll_mode) |-> intbcd_out == '0);

  // R2
  reserved_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~AVAIL_MASK) == '0);

  // R7
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & trig_mask & $past(irq_out) & $past(trig_mask)) == '0);

  // R8
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!serr_n || !iochk_n) && $past(!nmi_mask) && !$past(nmi_wr)) |-> nmi);

  // R8
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nmi) && !$past(nmi_wr)) |-> nmi);
endmodule

bind irq_steer_router irq_steer_router_chk #(
  .SEL_W      (SEL_W),
  .CFG_AW     (CFG_AW),
  .NMI_ADDR   (ADDR_NMI),
  .AVAIL_MASK (AVAIL_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .poll_mode  (poll_mode),
  .intbcd_out (intbcd_out),
  .irq_out    (irq_out),
  .trig_mask  (trig_mask),
  .nmi        (nmi),
  .nmi_mask   (nmi_mask),
  .serr_n     (serr_n),
  .iochk_n    (iochk_n),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr)
);

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        poll_mode;
  logic        inta_n;
  logic [2:0]  intbcd_in_n;
  logic [2:0]  intbcd_out;
  logic        intbcd_oe;
  logic [1:0]  xirq;
  logic        serr_n, iochk_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] irq_out;
  logic        nmi;

  logic [3:0]  dir_n;
  logic [7:0]  pat_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // external multiplexer model for polled mode
  assign inta_n      = poll_mode ? pat_n[intbcd_out] : dir_n[0];
  assign intbcd_in_n = dir_n[3:1];

  irq_steer_router u_dut (
    .clk (clk), .rst_n (rst_n), .poll_mode (poll_mode), .inta_n (inta_n),
    .intbcd_in_n (intbcd_in_n), .intbcd_out (intbcd_out), .intbcd_oe (intbcd_oe),
    .xirq (xirq), .serr_n (serr_n), .iochk_n (iochk_n), .cfg_we (cfg_we),
    .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .irq_out (irq_out), .nmi (nmi)
  );

  // {dir_n[3:0] (bit0 = source 0), xirq[1:0], expected irq_out}
  localparam logic [21:0] VECS [8] = '{
    {4'b1111, 2'b00, 16'h0000},
    {4'b1110, 2'b00, 16'h0020},
    {4'b1101, 2'b00, 16'h0200},
    {4'b1011, 2'b00, 16'h0200},
    {4'b0111, 2'b00, 16'h0000},
    {4'b1111, 2'b01, 16'h0400},
    {4'b1111, 2'b10, 16'h0000},
    {4'b0000, 2'b11, 16'h0620}
  };

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; poll_mode = 1'b0; dir_n = 4'hF; pat_n = 8'hFF; xirq = '0;
    serr_n = 1'b1; iochk_n = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R10 reset state
    chk("R10 irq_out", 32'(irq_out), 32'h0);
    chk("R10 nmi", 32'(nmi), 32'h0);
    chk("R10 select", {28'h0, intbcd_oe, intbcd_out}, 32'h0);
    // R10 entries disabled after reset: asserting source 0 routes nowhere
    dir_n = 4'b0000; xirq = 2'b11;
    step(2);
    chk("R10 entries disabled", 32'(irq_out), 32'h0);
    dir_n = 4'hF; xirq = 2'b00;

    wr(4'd0, 16'h15); wr(4'd1, 16'h19); wr(4'd2, 16'h19); wr(4'd3, 16'h12);
    wr(4'd4, 16'h1C); wr(4'd5, 16'h1E); wr(4'd6, 16'h11); wr(4'd7, 16'h14);
    wr(4'd8, 16'h1A); wr(4'd9, 16'h07);
    step(2);

    // R1 R2 R3 R4 level routing vectors
    for (int v = 0; v < 8; v++) begin
      dir_n = VECS[v][21:18];
      xirq  = VECS[v][17:16];
      step(2);
      chk("R1 R2 R3 R4 vector", 32'(irq_out), 32'(VECS[v][15:0]));
    end

    // R4 latency: one edge is not yet enough
    dir_n = 4'hF; xirq = 2'b00; step(2);
    dir_n = 4'b1110; step(1);
    chk("R4 latency one edge", 32'(irq_out), 32'h0);
    step(1);
    chk("R4 latency two edges", 32'(irq_out), 32'h20);
    dir_n = 4'hF; step(2);

    // R7 edge mode on line 9 shared by sources 1 and 2
    wr(4'd10, 16'h0200);
    dir_n = 4'b1101; step(2);
    chk("R7 pulse high", 32'(irq_out), 32'h0200);
    step(1);
    chk("R7 pulse one cycle", 32'(irq_out), 32'h0);
    dir_n = 4'b1001; step(2);
    chk("R7 second sharer no pulse", 32'(irq_out), 32'h0);
    dir_n = 4'b1011; step(2);
    chk("R7 partial release no pulse", 32'(irq_out), 32'h0);
    dir_n = 4'b1111; step(2);
    dir_n = 4'b1011; step(2);
    chk("R7 new pulse after release", 32'(irq_out), 32'h0200);
    dir_n = 4'hF; wr(4'd10, 16'h0000); step(2);

    // R5 polled select
    poll_mode = 1'b1;
    step(1);
    chk("R5 oe high", 32'(intbcd_oe), 32'h1);
    for (int k = 0; k < 8; k++) begin
      logic [2:0] s;
      s = intbcd_out;
      step(1);
      chk("R5 select advance", 32'(intbcd_out), 32'(3'(s + 3'd1)));
    end
    // R6 polled capture: sources 0, 4, 5 asserted
    pat_n = ~8'b0011_0001;
    step(20);
    chk("R6 polled routing", 32'(irq_out), 32'h5020);
    while (intbcd_out != 3'd0) step(1);
    pat_n[7] = 1'b0;
    step(8);
    chk("R6 held until scan commits", 32'(irq_out), 32'h5020);
    step(1);
    chk("R6 update after commit", 32'(irq_out), 32'h5030);
    poll_mode = 1'b0; pat_n = 8'hFF;
    step(1);
    chk("R5 idle select", {28'h0, intbcd_oe, intbcd_out}, 32'h0);
    step(2);

    // R8 sticky NMI
    serr_n = 1'b0; step(1); serr_n = 1'b1;
    chk("R8 serr sets nmi", 32'(nmi), 32'h1);
    step(3);
    chk("R8 nmi sticky", 32'(nmi), 32'h1);
    wr(4'd11, 16'h0002);
    chk("R9 clear drops nmi", 32'(nmi), 32'h0);
    iochk_n = 1'b0; step(1); iochk_n = 1'b1;
    chk("R8 iochk sets nmi", 32'(nmi), 32'h1);
    wr(4'd11, 16'h0001);
    chk("R9 mask write drops nmi", 32'(nmi), 32'h0);
    serr_n = 1'b0; step(2); serr_n = 1'b1;
    chk("R9 masked error ignored", 32'(nmi), 32'h0);
    wr(4'd11, 16'h0000);
    step(1);
    chk("R9 unmask alone keeps low", 32'(nmi), 32'h0);

    // R10 mid-run reset clears the line outputs and routing
    dir_n = 4'b1110; step(2);
    rst_n = 1'b0; #1;
    chk("R10 async reset output", 32'(irq_out), 32'h0);
    step(2); rst_n = 1'b1; step(4);
    chk("R10 table cleared", 32'(irq_out), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule